// File: doc/BRIEF.md
# Store-Exclusive Halfword Execution Unit

This unit executes one store-exclusive halfword operation against a local exclusive monitor. It decodes a 32-bit instruction word and drives the base and data register indices to a register-file read port. It forms the effective address from a general register or the stack pointer, then compares that address with the address recorded by a preceding load-exclusive. When the monitor passes and the address is aligned, it issues a single-cycle 2-byte write. In every case that reaches writeback, it returns a zero-extended 32-bit status to the status register.

Some cases raise a fault instead of a result. Decode problems raise one. So does a stack pointer that is not 16-byte aligned, and so does a halfword misalignment. A fault blocks both the memory write and the status writeback. Cases where the status register index overlaps the data or base index are resolved by a 2-bit policy input. All results appear on registered outputs one clock after the instruction is presented.

Top module: `stex_half_unit`

## Requirements
- R1: An instruction is accepted only when instValid is high, instWord[31:21] equals 11'b01001000000 and instWord[15] is 0. The fields are status index [20:16], base index [9:5] and data index [4:0]. Any other word produces no output and leaves the monitor untouched.
- R2: A cycle with armValid high records armAddr and marks the monitor valid. The monitor passes when it is valid and the store address equals the recorded address in all bits above bit 0 (halfword granule).
- R3: When the monitor passes and address bit 0 is 0, the cycle after acceptance shows memWrEn with memAddr set to the address and memData set to the low 16 bits of the data register. In that same cycle wbValid is high with wbIdx set to the status index and wbValue set to 0.
- R4: When the monitor fails and no fault is raised, memWrEn stays low and wbValid is high with wbValue set to 1.
- R5: Every store that reaches the monitor check clears the monitor, whether it passes or fails. The clearing store includes one that then takes an alignment fault.
- R6: When address bit 0 is 1 and the monitor passes, faultValid is raised with faultCode 1 (alignment), with no write and no writeback. When the monitor fails, the fault is raised only if alignOnFail is 1; otherwise status 1 is written back.
- R7: A base index of 31 takes the address from spVal. If spVal[3:0] is nonzero, faultCode 2 (stack alignment) is raised, with no write, no writeback and no change to the monitor.
- R8: When instWord[14:10] is not all ones and badFieldUndef is 1, faultCode 3 (undefined) is raised. When badFieldUndef is 0, the field is ignored.
- R9: When the status index equals the data index, overlapPolicy selects the outcome. 0 stores UNK_DATA (default 16'hBAD5); 1 stores the register value; 2 raises faultCode 3; 3 does nothing at all, leaving the monitor unchanged.
- R10: When the status index equals the base index and the base index is not 31, overlapPolicy selects the outcome. 0 uses UNK_ADDR (default 64'h100) as the address; 1 uses the register; 2 raises faultCode 3; 3 does nothing at all.
- R11: Fault priority is undefined (3), then stack alignment (2), then alignment (1). A fault output never coincides with memWrEn or wbValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| armValid | input | 1 | Load-exclusive arm strobe |
| armAddr | input | 64 | Address to record in the monitor |
| instValid | input | 1 | Instruction word valid |
| instWord | input | 32 | Instruction word |
| rdBaseIdx | output | 5 | Register-file read index for the base |
| rdDataIdx | output | 5 | Register-file read index for the data |
| regBaseVal | input | 64 | Base register value (combinational read) |
| regDataVal | input | 16 | Low halfword of the data register |
| spVal | input | 64 | Stack pointer value |
| overlapPolicy | input | 2 | Overlap resolution: 0 unknown, 1 original, 2 undefined, 3 do nothing |
| alignOnFail | input | 1 | Raise alignment fault when the monitor fails |
| badFieldUndef | input | 1 | Treat a bad [14:10] field as undefined |
| memWrEn | output | 1 | Single-cycle 2-byte write strobe |
| memAddr | output | 64 | Write address |
| memData | output | 16 | Write data |
| wbValid | output | 1 | Status writeback strobe |
| wbIdx | output | 5 | Status register index |
| wbValue | output | 32 | Zero-extended status |
| faultValid | output | 1 | Fault strobe |
| faultCode | output | 2 | 1 alignment, 2 stack alignment, 3 undefined |

## Verification
Some paths skip the monitor check: do-nothing overlaps, undefined decodes, stack faults and rejected opcodes. The hardest thing to show from the ports is that these leave the monitor state intact, while an alignment fault clears it. The monitor is not visible, so the stimulus arms the monitor first and then sends the skipping instruction. It follows with an ordinary store to the armed address, whose pass or fail status reveals the hidden state. An odd address inside the armed halfword granule forces the pass-plus-misaligned combination.

// File: rtl/stex_pkg.sv
package stex_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_SP    = 2'd2,
    FLT_UNDEF = 2'd3
  } faultCode_e;

  typedef enum logic [1:0] {
    POL_UNKNOWN  = 2'd0,
    POL_ORIGINAL = 2'd1,
    POL_UNDEF    = 2'd2,
    POL_NOTHING  = 2'd3
  } overlapPol_e;

  // address/data source selection; depends on decode only
  typedef struct packed {
    logic useSp;
    logic unkAddr;
    logic unkData;
  } srcSel_t;

  // action strobes for the output stage
  typedef struct packed {
    logic       doStore;
    logic       doWb;
    logic       statusBit;
    logic [4:0] wbIdx;
    logic       doFault;
    faultCode_e code;
  } action_t;

  localparam logic [10:0] OPC_STXH = 11'b01001000000;

endpackage

// File: rtl/stex_ctrl.sv
module stex_ctrl
  import stex_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int GRAN_LOG2     = 1,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armValid,
  input  logic [ADDR_W-1:0] armAddr,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [1:0]        overlapPolicy,
  input  logic              alignOnFail,
  input  logic              badFieldUndef,
  input  logic [ADDR_W-1:0] effAddr,
  output logic [4:0]        rdBaseIdx,
  output logic [4:0]        rdDataIdx,
  output srcSel_t           sel,
  output action_t           act
);

  localparam int TAG_W = ADDR_W - GRAN_LOG2;

  logic             monValid;
  logic [TAG_W-1:0] monTag;

  logic [4:0]  sIdx, nIdx, tIdx;
  logic        opOk, fieldBad, ovData, ovBase, isUndef, isNothing;
  logic        spFault, reach, monPass, misAligned, alignFault;
  overlapPol_e pol;

  always_comb begin
    sIdx      = instWord[20:16];
    nIdx      = instWord[9:5];
    tIdx      = instWord[4:0];
    pol       = overlapPol_e'(overlapPolicy);
    opOk      = instValid && (instWord[31:21] == OPC_STXH) && !instWord[15];
    fieldBad  = instWord[14:10] != 5'b11111;
    ovData    = sIdx == tIdx;
    ovBase    = (sIdx == nIdx) && (nIdx != 5'd31);
    isUndef   = (fieldBad && badFieldUndef)
              || ((ovData || ovBase) && pol == POL_UNDEF);
    isNothing = !isUndef && (ovData || ovBase) && pol == POL_NOTHING;
  end

  assign rdBaseIdx = nIdx;
  assign rdDataIdx = tIdx;

  always_comb begin
    sel.useSp   = nIdx == 5'd31;
    sel.unkAddr = ovBase && pol == POL_UNKNOWN;
    sel.unkData = ovData && pol == POL_UNKNOWN;
  end

  always_comb begin
    spFault    = opOk && !isUndef && !isNothing && sel.useSp
               && (effAddr[SP_ALIGN_LOG2-1:0] != '0);
    reach      = opOk && !isUndef && !isNothing && !spFault;
    monPass    = monValid && (effAddr[ADDR_W-1:GRAN_LOG2] == monTag);
    misAligned = effAddr[0];
    alignFault = reach && misAligned && (monPass || alignOnFail);

    act.doStore   = reach && monPass && !misAligned;
    act.doWb      = reach && !alignFault;
    act.statusBit = !(monPass && !misAligned);
    act.wbIdx     = sIdx;
    act.doFault   = (opOk && isUndef) || spFault || alignFault;
    if (opOk && isUndef)  act.code = FLT_UNDEF;
    else if (spFault)     act.code = FLT_SP;
    else if (alignFault)  act.code = FLT_ALIGN;
    else                  act.code = FLT_NONE;
  end

  // monitor: an arm in the same cycle as a store leaves the arm in effect
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      monValid <= 1'b0;
      monTag   <= '0;
    end else if (armValid) begin
      monValid <= 1'b1;
      monTag   <= armAddr[ADDR_W-1:GRAN_LOG2];
    end else if (reach) begin
      monValid <= 1'b0;
    end
  end

  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armValid |=> monValid);
  p_check_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reach && !armValid) |=> !monValid);
  p_store_needs_mon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act.doStore |-> monValid);
  p_skip_keeps_mon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (opOk && isNothing && !armValid) |=> $stable(monValid));

endmodule

// File: rtl/stex_dpath.sv
module stex_dpath
  import stex_pkg::*;
#(
  parameter int              ADDR_W   = 64,
  parameter logic [63:0]     UNK_ADDR = 64'h100,
  parameter logic [15:0]     UNK_DATA = 16'hBAD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srcSel_t           sel,
  input  action_t           act,
  input  logic [ADDR_W-1:0] regBaseVal,
  input  logic [15:0]       regDataVal,
  input  logic [ADDR_W-1:0] spVal,
  output logic [ADDR_W-1:0] effAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic              wbValid,
  output logic [4:0]        wbIdx,
  output logic [31:0]       wbValue,
  output logic              faultValid,
  output logic [1:0]        faultCode
);

  logic [15:0] storeData;

  always_comb begin
    if (sel.useSp)        effAddr = spVal;
    else if (sel.unkAddr) effAddr = UNK_ADDR[ADDR_W-1:0];
    else                  effAddr = regBaseVal;
    storeData = sel.unkData ? UNK_DATA : regDataVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memWrEn    <= 1'b0;
      memAddr    <= '0;
      memData    <= '0;
      wbValid    <= 1'b0;
      wbIdx      <= '0;
      wbValue    <= '0;
      faultValid <= 1'b0;
      faultCode  <= '0;
    end else begin
      memWrEn    <= act.doStore;
      memAddr    <= effAddr;
      memData    <= storeData;
      wbValid    <= act.doWb;
      wbIdx      <= act.wbIdx;
      wbValue    <= {31'd0, act.statusBit};
      faultValid <= act.doFault;
      faultCode  <= act.code;
    end
  end

  p_fault_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |-> (!memWrEn && !wbValid));
  p_store_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> (wbValid && wbValue == 32'd0));
  p_fail_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !memWrEn) |-> (wbValue == 32'd1));
  p_code_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |-> (faultCode != 2'd0));

endmodule

// File: rtl/stex_half_unit.sv
module stex_half_unit
  import stex_pkg::*;
#(
  parameter int          ADDR_W        = 64,
  parameter int          GRAN_LOG2     = 1,
  parameter int          SP_ALIGN_LOG2 = 4,
  parameter logic [63:0] UNK_ADDR      = 64'h100,
  parameter logic [15:0] UNK_DATA      = 16'hBAD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armValid,
  input  logic [ADDR_W-1:0] armAddr,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  output logic [4:0]        rdBaseIdx,
  output logic [4:0]        rdDataIdx,
  input  logic [ADDR_W-1:0] regBaseVal,
  input  logic [15:0]       regDataVal,
  input  logic [ADDR_W-1:0] spVal,
  input  logic [1:0]        overlapPolicy,
  input  logic              alignOnFail,
  input  logic              badFieldUndef,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic              wbValid,
  output logic [4:0]        wbIdx,
  output logic [31:0]       wbValue,
  output logic              faultValid,
  output logic [1:0]        faultCode
);

  srcSel_t           sel;
  action_t           act;
  logic [ADDR_W-1:0] effAddr;

  stex_ctrl #(
    .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .SP_ALIGN_LOG2(SP_ALIGN_LOG2)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .armValid(armValid), .armAddr(armAddr),
    .instValid(instValid), .instWord(instWord),
    .overlapPolicy(overlapPolicy), .alignOnFail(alignOnFail),
    .badFieldUndef(badFieldUndef), .effAddr(effAddr),
    .rdBaseIdx(rdBaseIdx), .rdDataIdx(rdDataIdx), .sel(sel), .act(act)
  );

  stex_dpath #(
    .ADDR_W(ADDR_W), .UNK_ADDR(UNK_ADDR), .UNK_DATA(UNK_DATA)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .sel(sel), .act(act),
    .regBaseVal(regBaseVal), .regDataVal(regDataVal), .spVal(spVal),
    .effAddr(effAddr), .memWrEn(memWrEn), .memAddr(memAddr),
    .memData(memData), .wbValid(wbValid), .wbIdx(wbIdx), .wbValue(wbValue),
    .faultValid(faultValid), .faultCode(faultCode)
  );

endmodule

// File: tb/tb_stex_half_unit.sv
`timescale 1ns/1ps
module tb_stex_half_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        armValid = 1'b0;
  logic [63:0] armAddr = '0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [4:0]  rdBaseIdx, rdDataIdx;
  logic [63:0] regBaseVal;
  logic [15:0] regDataVal;
  logic [63:0] spVal = 64'h4000;
  logic [1:0]  overlapPolicy = 2'd1;
  logic        alignOnFail = 1'b0;
  logic        badFieldUndef = 1'b1;
  logic        memWrEn, wbValid, faultValid;
  logic [63:0] memAddr;
  logic [15:0] memData;
  logic [4:0]  wbIdx;
  logic [31:0] wbValue;
  logic [1:0]  faultCode;

  logic [63:0] regs [0:31];

  always #5 clk = ~clk;

  assign regBaseVal = regs[rdBaseIdx];
  assign regDataVal = regs[rdDataIdx][15:0];

  stex_half_unit dut (
    .clk(clk), .rst_n(rst_n), .armValid(armValid), .armAddr(armAddr),
    .instValid(instValid), .instWord(instWord),
    .rdBaseIdx(rdBaseIdx), .rdDataIdx(rdDataIdx),
    .regBaseVal(regBaseVal), .regDataVal(regDataVal), .spVal(spVal),
    .overlapPolicy(overlapPolicy), .alignOnFail(alignOnFail),
    .badFieldUndef(badFieldUndef), .memWrEn(memWrEn), .memAddr(memAddr),
    .memData(memData), .wbValid(wbValid), .wbIdx(wbIdx), .wbValue(wbValue),
    .faultValid(faultValid), .faultCode(faultCode)
  );

  typedef struct {
    int          kind;   // 0 nothing, 1 store, 2 status-only, 3 fault
    logic [63:0] addr;
    logic [15:0] data;
    logic [4:0]  idx;
    logic [31:0] val;
    logic [1:0]  code;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  logic issuedD = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] s, input logic [4:0] n,
                                      input logic [4:0] t);
    return {11'b01001000000, s, 1'b0, 5'b11111, n, t};
  endfunction

  function automatic expItem_t eStore(input logic [63:0] a, input logic [15:0] d,
                                      input logic [4:0] i, input string r);
    expItem_t e;
    e.kind = 1; e.addr = a; e.data = d; e.idx = i; e.val = 0; e.code = 0; e.req = r;
    return e;
  endfunction

  function automatic expItem_t eFail(input logic [4:0] i, input string r);
    expItem_t e;
    e.kind = 2; e.addr = 0; e.data = 0; e.idx = i; e.val = 1; e.code = 0; e.req = r;
    return e;
  endfunction

  function automatic expItem_t eFault(input logic [1:0] c, input string r);
    expItem_t e;
    e.kind = 3; e.addr = 0; e.data = 0; e.idx = 0; e.val = 0; e.code = c; e.req = r;
    return e;
  endfunction

  function automatic expItem_t eNone(input string r);
    expItem_t e;
    e.kind = 0; e.addr = 0; e.data = 0; e.idx = 0; e.val = 0; e.code = 0; e.req = r;
    return e;
  endfunction

  task automatic issue(input logic [31:0] w, input expItem_t e);
    @(negedge clk);
    instWord = w;
    instValid = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic arm(input logic [63:0] a);
    @(negedge clk);
    armValid = 1'b1;
    armAddr = a;
    @(negedge clk);
    armValid = 1'b0;
  endtask

  always @(posedge clk) issuedD <= rst_n && instValid;

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (issuedD) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R1", "unexpected result", 0, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(memWrEn == (e.kind == 1), e.req, "memWrEn", memWrEn, e.kind == 1);
          chk(wbValid == (e.kind == 1 || e.kind == 2), e.req, "wbValid",
              wbValid, e.kind == 1 || e.kind == 2);
          chk(faultValid == (e.kind == 3), e.req, "faultValid", faultValid, e.kind == 3);
          if (e.kind == 1) begin
            chk(memAddr == e.addr, e.req, "memAddr", memAddr, e.addr);
            chk(memData == e.data, e.req, "memData", memData, e.data);
          end
          if (e.kind == 1 || e.kind == 2) begin
            chk(wbIdx == e.idx, e.req, "wbIdx", wbIdx, e.idx);
            chk(wbValue == e.val, e.req, "wbValue", wbValue, e.val);
          end
          if (e.kind == 3)
            chk(faultCode == e.code, e.req, "faultCode", faultCode, e.code);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(1'b0, "WATCHDOG", "timeout", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'(i) * 64'h1111;
    repeat (3) @(negedge clk);
    // reset state
    chk(!memWrEn && !wbValid && !faultValid, "R1", "reset outputs", 
        {memWrEn, wbValid, faultValid}, 0);
    rst_n = 1'b1;

    // R2/R3: basic pass
    regs[2] = 64'h1000; regs[3] = 64'hABCD_1234;
    arm(64'h1000);
    issue(enc(5'd1, 5'd2, 5'd3), eStore(64'h1000, 16'h1234, 5'd1, "R3"));
    // R5: monitor cleared by the previous store
    issue(enc(5'd1, 5'd2, 5'd3), eFail(5'd1, "R5"));
    // R4: never armed
    issue(enc(5'd8, 5'd2, 5'd3), eFail(5'd8, "R4"));

    // R2 granule: other halfword fails, same halfword passes
    regs[4] = 64'h2002;
    arm(64'h2000);
    issue(enc(5'd1, 5'd4, 5'd3), eFail(5'd1, "R2"));
    regs[4] = 64'h2000;
    arm(64'h2001);
    issue(enc(5'd1, 5'd4, 5'd3), eStore(64'h2000, 16'h1234, 5'd1, "R2"));

    // R6: misaligned inside armed granule -> fault; monitor then cleared (R5)
    regs[4] = 64'h3001;
    arm(64'h3000);
    issue(enc(5'd1, 5'd4, 5'd3), eFault(2'd1, "R6"));
    regs[4] = 64'h3000;
    issue(enc(5'd1, 5'd4, 5'd3), eFail(5'd1, "R5"));
    // R6 monitor fails
    regs[4] = 64'h3001;
    alignOnFail = 1'b0;
    issue(enc(5'd1, 5'd4, 5'd3), eFail(5'd1, "R6"));
    alignOnFail = 1'b1;
    issue(enc(5'd1, 5'd4, 5'd3), eFault(2'd1, "R6"));
    alignOnFail = 1'b0;

    // R7: stack pointer base
    spVal = 64'h4000;
    arm(64'h4000);
    issue(enc(5'd1, 5'd31, 5'd3), eStore(64'h4000, 16'h1234, 5'd1, "R7"));
    spVal = 64'h4008;
    arm(64'h4008);
    issue(enc(5'd1, 5'd31, 5'd3), eFault(2'd2, "R7"));
    regs[4] = 64'h4008;
    issue(enc(5'd1, 5'd4, 5'd3), eStore(64'h4008, 16'h1234, 5'd1, "R7 monitor kept"));
    // R10 exclusion: status and base both 31
    spVal = 64'h4010;
    arm(64'h4010);
    issue(enc(5'd31, 5'd31, 5'd3), eStore(64'h4010, 16'h1234, 5'd31, "R10"));

    // R8: bad [14:10]
    regs[4] = 64'h5000;
    arm(64'h5000);
    badFieldUndef = 1'b1;
    issue(enc(5'd1, 5'd4, 5'd3) & ~32'h0000_0400, eFault(2'd3, "R8"));
    badFieldUndef = 1'b0;
    issue(enc(5'd1, 5'd4, 5'd3) & ~32'h0000_0400,
          eStore(64'h5000, 16'h1234, 5'd1, "R8"));
    badFieldUndef = 1'b1;

    // R1: rejected opcodes leave monitor
    arm(64'h5000);
    issue(enc(5'd1, 5'd4, 5'd3) | 32'h0000_8000, eNone("R1"));
    issue(enc(5'd1, 5'd4, 5'd3) | 32'h0040_0000, eNone("R1"));
    issue(enc(5'd1, 5'd4, 5'd3), eStore(64'h5000, 16'h1234, 5'd1, "R1 monitor kept"));

    // R9: status == data
    regs[5] = 64'h5555_7777; regs[6] = 64'h6000;
    overlapPolicy = 2'd0;
    arm(64'h6000);
    issue(enc(5'd5, 5'd6, 5'd5), eStore(64'h6000, 16'hBAD5, 5'd5, "R9"));
    overlapPolicy = 2'd1;
    arm(64'h6000);
    issue(enc(5'd5, 5'd6, 5'd5), eStore(64'h6000, 16'h7777, 5'd5, "R9"));
    overlapPolicy = 2'd2;
    issue(enc(5'd5, 5'd6, 5'd5), eFault(2'd3, "R9"));
    overlapPolicy = 2'd3;
    arm(64'h6000);
    issue(enc(5'd5, 5'd6, 5'd5), eNone("R9"));
    overlapPolicy = 2'd1;
    issue(enc(5'd1, 5'd6, 5'd3), eStore(64'h6000, 16'h1234, 5'd1, "R9 monitor kept"));

    // R10: status == base
    regs[7] = 64'h7000;
    overlapPolicy = 2'd0;
    arm(64'h100);
    issue(enc(5'd7, 5'd7, 5'd3), eStore(64'h100, 16'h1234, 5'd7, "R10"));
    overlapPolicy = 2'd1;
    arm(64'h7000);
    issue(enc(5'd7, 5'd7, 5'd3), eStore(64'h7000, 16'h1234, 5'd7, "R10"));
    overlapPolicy = 2'd2;
    issue(enc(5'd7, 5'd7, 5'd3), eFault(2'd3, "R10"));
    overlapPolicy = 2'd3;
    arm(64'h7000);
    issue(enc(5'd7, 5'd7, 5'd3), eNone("R10"));
    overlapPolicy = 2'd1;
    issue(enc(5'd1, 5'd7, 5'd3), eStore(64'h7000, 16'h1234, 5'd1, "R10 monitor kept"));

    // R11: priorities
    spVal = 64'h4001;
    arm(64'h4000);
    issue(enc(5'd1, 5'd31, 5'd3), eFault(2'd2, "R11"));
    issue(enc(5'd1, 5'd31, 5'd3) & ~32'h0000_0400, eFault(2'd3, "R11"));

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R1", "pending expectations", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule